// File: doc/BRIEF.md
# Stack and Indirect-Jump Instruction Sequencer

This block is a small execution unit for an 8-bit processor whose general registers pair up into 16-bit words. Once the front end has fetched an opcode byte, it hands that byte over with a one-cycle `start` strobe. The unit then executes one of four control-flow instructions:

- copy the HL pair into the stack pointer;
- jump to the address held in HL;
- plain subroutine return;
- interrupt return.

The unit owns the program counter, the stack pointer, the HL pair, the flag byte and the interrupt master enable. On the last machine cycle of each instruction it pulses `done` together with the number of machine cycles the instruction used. One machine cycle is one clock here.

The two returns read the stack through a byte-wide memory read port. That port is combinational: the address and enable leave the block, and the data comes back in the same cycle. While the unit is idle, the rest of the core can preload any register through a simple write port.

Top module: `stkjmp_seq`

## Requirements
- R1: Opcode 0xF9 copies HL into SP and leaves HL unchanged. Any value moves through exactly, including 0x0000 and 0xFFFF. `done` pulses with a count of 2 in the second cycle after acceptance.
- R2: None of the four instructions (0xF9, 0xE9, 0xC9, 0xD9) alter the flag byte. Only the write port with select 3 changes it.
- R3: Opcode 0xE9 loads PC from HL with no memory read. `done` pulses with a count of 1 in the cycle after acceptance.
- R4: Opcode 0xD9 pops a return address into PC and sets the interrupt enable to 1. `done` pulses with a count of 4.
- R5: Opcode 0xC9 pops a return address into PC exactly as 0xD9 does and leaves the interrupt enable unchanged. `done` pulses with a count of 4.
- R6: A pop reads the low byte at SP, then the high byte at SP+1 in the next cycle. It leaves SP increased by 2 modulo 65536, so SP=0xFFFF reads 0xFFFF, then 0x0000, and ends at 0x0001.
- R7: For opcode 0xF9, PC after the instruction is the opcode address plus 1, wrapping at 16 bits.
- R8: Any other opcode raises `illegal` for one cycle. It changes no register, reads no memory and produces no `done`.
- R9: A `start` while an instruction is in progress is ignored. It produces no extra `done` and no register change.
- R10: While reset is held, PC, SP, HL, flags, interrupt enable, `done`, `illegal` and `mem_rd_en` are all 0.
- R11: With the unit idle, `reg_we` writes `reg_wdata` into the register chosen by `reg_sel`, visible on the next cycle. The selects are: 0 PC, 1 SP, 2 HL, 3 flags (low 8 bits), 4 interrupt enable (bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opcode valid strobe, accepted only when idle |
| opcode | input | 8 | Fetched opcode byte |
| reg_we | input | 1 | Register preload strobe, honoured only when idle |
| reg_sel | input | 3 | Register select for preload |
| reg_wdata | input | 16 | Preload data |
| mem_rd_en | output | 1 | Stack read enable |
| mem_addr | output | 16 | Stack read address |
| mem_rdata | input | 8 | Stack read data, same cycle |
| done | output | 1 | Instruction completion pulse |
| cyc_count | output | 3 | Machine cycles used, valid with `done`, 0 otherwise |
| illegal | output | 1 | Unsupported-opcode pulse |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| hl_o | output | 16 | HL pair |
| flags_o | output | 8 | Flag byte |
| ime_o | output | 1 | Interrupt master enable |

## Verification
The bound checker watches four things on every cycle:

- the flag byte stays frozen except on a preload;
- SP equals HL whenever a two-cycle completion is reported;
- PC equals HL after a one-cycle completion, with no read in the cycle before;
- consecutive stack reads step the address by one, and `done` only ever carries a legal count.

Other behaviour can only be shown by the bench's scenarios, because the ports alone do not distinguish it:

- whether a completion came from the plain return or the interrupt return, and so whether the interrupt enable was restored or left unchanged;
- the exact popped address at the 0xFFFF wrap;
- that an illegal opcode or a start during a busy instruction leaves every register untouched.

// File: rtl/stkjmp_pkg.sv
package stkjmp_pkg;

   localparam logic [7:0] OP_LD_SP_HL = 8'hF9;
   localparam logic [7:0] OP_JP_HL    = 8'hE9;
   localparam logic [7:0] OP_RET      = 8'hC9;
   localparam logic [7:0] OP_RETI     = 8'hD9;

   localparam int CYC_JP   = 1;
   localparam int CYC_LDSP = 2;
   localparam int CYC_RET  = 4;

   localparam logic [2:0] SEL_PC  = 3'd0;
   localparam logic [2:0] SEL_SP  = 3'd1;
   localparam logic [2:0] SEL_HL  = 3'd2;
   localparam logic [2:0] SEL_FLG = 3'd3;
   localparam logic [2:0] SEL_IME = 3'd4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LDSP,
      ST_POPL,
      ST_POPH,
      ST_RETW
   } seq_state_t;

   typedef struct packed {
      logic pc_inc;
      logic pc_from_hl;
      logic sp_from_hl;
      logic lo_cap;
      logic hi_cap;
      logic sp_inc;
      logic pc_from_pop;
      logic ime_set;
   } seq_ctl_t;

endpackage

// File: rtl/stkjmp_ctrl.sv
module stkjmp_ctrl
   import stkjmp_pkg::*;
#(
   parameter int OP_W  = 8,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [OP_W-1:0]  opcode,
   output seq_ctl_t         ctl,
   output logic             idle,
   output logic             rd_en,
   output logic             done,
   output logic [CNT_W-1:0] cyc_count,
   output logic             illegal
);

   generate
      if (CNT_W < 3) begin : g_cnt_chk
         $error("CNT_W must hold the longest cycle budget");
      end
      if (OP_W != 8) begin : g_op_chk
         $error("OP_W must be 8");
      end
   endgenerate

   seq_state_t       state_q, state_d;
   logic             reti_q, reti_d;
   logic             fin, ill;
   logic [CNT_W-1:0] cnt;

   always_comb begin
      ctl     = '0;
      state_d = state_q;
      reti_d  = reti_q;
      fin     = 1'b0;
      ill     = 1'b0;
      cnt     = '0;
      rd_en   = 1'b0;
      unique case (state_q)
         ST_IDLE: if (start) begin
            unique case (opcode)
               OP_LD_SP_HL: begin
                  ctl.pc_inc = 1'b1;
                  state_d    = ST_LDSP;
               end
               OP_JP_HL: begin
                  ctl.pc_from_hl = 1'b1;
                  fin            = 1'b1;
                  cnt            = CNT_W'(CYC_JP);
               end
               OP_RET, OP_RETI: begin
                  ctl.pc_inc = 1'b1;
                  reti_d     = (opcode == OP_RETI);
                  state_d    = ST_POPL;
               end
               default: ill = 1'b1;
            endcase
         end
         ST_LDSP: begin
            ctl.sp_from_hl = 1'b1;
            fin            = 1'b1;
            cnt            = CNT_W'(CYC_LDSP);
            state_d        = ST_IDLE;
         end
         ST_POPL: begin
            rd_en      = 1'b1;
            ctl.lo_cap = 1'b1;
            ctl.sp_inc = 1'b1;
            state_d    = ST_POPH;
         end
         ST_POPH: begin
            rd_en      = 1'b1;
            ctl.hi_cap = 1'b1;
            ctl.sp_inc = 1'b1;
            state_d    = ST_RETW;
         end
         ST_RETW: begin
            ctl.pc_from_pop = 1'b1;
            ctl.ime_set     = reti_q;
            fin             = 1'b1;
            cnt             = CNT_W'(CYC_RET);
            state_d         = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign idle = (state_q == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         reti_q    <= 1'b0;
         done      <= 1'b0;
         cyc_count <= '0;
         illegal   <= 1'b0;
      end else begin
         state_q   <= state_d;
         reti_q    <= reti_d;
         done      <= fin;
         cyc_count <= cnt;
         illegal   <= ill;
      end
   end

endmodule

// File: rtl/stkjmp_regs.sv
module stkjmp_regs
   import stkjmp_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  seq_ctl_t          ctl,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] sp,
   output logic [ADDR_W-1:0] hl,
   output logic [DATA_W-1:0] flags,
   output logic              ime
);

   localparam int PAIR_W = 2 * DATA_W;

   generate
      if (ADDR_W != PAIR_W) begin : g_pair_chk
         $error("ADDR_W must equal two data bytes");
      end
   endgenerate

   logic [DATA_W-1:0] lo_q, hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc    <= '0;
         sp    <= '0;
         hl    <= '0;
         flags <= '0;
         ime   <= 1'b0;
         lo_q  <= '0;
         hi_q  <= '0;
      end else begin
         if (wr_en) begin
            unique case (wr_sel)
               SEL_PC:  pc    <= wr_data;
               SEL_SP:  sp    <= wr_data;
               SEL_HL:  hl    <= wr_data;
               SEL_FLG: flags <= wr_data[DATA_W-1:0];
               SEL_IME: ime   <= wr_data[0];
               default: ;
            endcase
         end
         if (ctl.pc_inc)      pc   <= pc + ADDR_W'(1);
         if (ctl.pc_from_hl)  pc   <= hl;
         if (ctl.pc_from_pop) pc   <= {hi_q, lo_q};
         if (ctl.sp_from_hl)  sp   <= hl;
         if (ctl.sp_inc)      sp   <= sp + ADDR_W'(1);
         if (ctl.lo_cap)      lo_q <= rd_data;
         if (ctl.hi_cap)      hi_q <= rd_data;
         if (ctl.ime_set)     ime  <= 1'b1;
      end
   end

endmodule

// File: rtl/stkjmp_seq.sv
module stkjmp_seq
   import stkjmp_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        opcode,
   input  logic              reg_we,
   input  logic [2:0]        reg_sel,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              done,
   output logic [CNT_W-1:0]  cyc_count,
   output logic              illegal,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] sp_o,
   output logic [ADDR_W-1:0] hl_o,
   output logic [DATA_W-1:0] flags_o,
   output logic              ime_o
);

   seq_ctl_t ctl;
   logic     idle;

   stkjmp_ctrl #(.OP_W(8), .CNT_W(CNT_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .opcode    (opcode),
      .ctl       (ctl),
      .idle      (idle),
      .rd_en     (mem_rd_en),
      .done      (done),
      .cyc_count (cyc_count),
      .illegal   (illegal)
   );

   stkjmp_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl     (ctl),
      .wr_en   (reg_we && idle),
      .wr_sel  (reg_sel),
      .wr_data (reg_wdata),
      .rd_data (mem_rdata),
      .pc      (pc_o),
      .sp      (sp_o),
      .hl      (hl_o),
      .flags   (flags_o),
      .ime     (ime_o)
   );

   assign mem_addr = sp_o;

endmodule

// File: rtl/stkjmp_seq_chk.sv
module stkjmp_seq_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic              mem_rd_en,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              done,
   input logic [CNT_W-1:0]  cyc_count,
   input logic              illegal,
   input logic [ADDR_W-1:0] pc_o,
   input logic [ADDR_W-1:0] sp_o,
   input logic [ADDR_W-1:0] hl_o,
   input logic [DATA_W-1:0] flags_o,
   input logic              ime_o
);

   AST_FLAGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_we |=> $stable(flags_o)); // R2

   AST_LDSP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cyc_count == 3'd2) |-> (sp_o == hl_o)); // R1

   AST_JP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cyc_count == 3'd1) |-> (pc_o == hl_o && !$past(mem_rd_en))); // R3

   AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1))); // R6

   AST_IME_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ime_o) |-> ($past(reg_we) || (done && cyc_count == 3'd4))); // R4

   AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cyc_count == 3'd1 || cyc_count == 3'd2 || cyc_count == 3'd4)); // R5

   AST_ILLEGAL_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !done); // R8

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!done && !illegal && !mem_rd_en)); // R10

endmodule

bind stkjmp_seq stkjmp_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .mem_rd_en (mem_rd_en),
   .mem_addr  (mem_addr),
   .done      (done),
   .cyc_count (cyc_count),
   .illegal   (illegal),
   .pc_o      (pc_o),
   .sp_o      (sp_o),
   .hl_o      (hl_o),
   .flags_o   (flags_o),
   .ime_o     (ime_o)
);

// File: tb/stkjmp_seq_bench.sv
`timescale 1ns/1ps
module stkjmp_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  opcode = 8'h00;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_sel = 3'd0;
   logic [15:0] reg_wdata = 16'h0;
   logic        mem_rd_en;
   logic [15:0] mem_addr;
   logic [7:0]  mem_rdata;
   logic        done;
   logic [2:0]  cyc_count;
   logic        illegal;
   logic [15:0] pc_o, sp_o, hl_o;
   logic [7:0]  flags_o;
   logic        ime_o;

   always #4 clk = ~clk;

   // Stack memory model: each byte is a function of its address.
   assign mem_rdata = mem_addr[7:0] ^ 8'hA5;

   stkjmp_seq u_stkjmp_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .done(done), .cyc_count(cyc_count), .illegal(illegal),
      .pc_o(pc_o), .sp_o(sp_o), .hl_o(hl_o), .flags_o(flags_o), .ime_o(ime_o)
   );

   typedef struct {
      logic [2:0]  cnt;
      logic [15:0] pc, sp, hl;
      logic [7:0]  fl;
      logic        ime;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   int          n_chk = 0;
   int          n_fail = 0;
   int          rd_cnt = 0;
   logic [15:0] m_pc = 0, m_sp = 0, m_hl = 0;
   logic [7:0]  m_fl = 0;
   logic        m_ime = 0;

   always @(posedge clk) if (mem_rd_en) rd_cnt <= rd_cnt + 1;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Monitor: compares each completion against the scoreboard head.
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            chk("R9 unexpected done", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk({e.tag, " count"}, 32'(cyc_count), 32'(e.cnt));
            chk({e.tag, " pc"},    32'(pc_o),      32'(e.pc));
            chk({e.tag, " sp"},    32'(sp_o),      32'(e.sp));
            chk({e.tag, " hl"},    32'(hl_o),      32'(e.hl));
            chk({e.tag, " flags R2"}, 32'(flags_o), 32'(e.fl));
            chk({e.tag, " ime"},   32'(ime_o),     32'(e.ime));
         end
      end
   end

   task automatic wr(input logic [2:0] sel, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      case (sel)
         3'd0: m_pc = d;
         3'd1: m_sp = d;
         3'd2: m_hl = d;
         3'd3: m_fl = d[7:0];
         default: m_ime = d[0];
      endcase
   endtask

   task automatic issue(input logic [7:0] op);
      @(negedge clk);
      start = 1'b1; opcode = op;
      @(negedge clk);
      start = 1'b0;
   endtask

   // Driver: computes the expected result, queues it, then starts the op.
   task automatic run(input logic [7:0] op, input string tag);
      exp_t e;
      int   rd0;
      logic [7:0] lo, hi;
      e.fl = m_fl; e.hl = m_hl; e.tag = tag;
      case (op)
         8'hF9: begin e.cnt = 3'd2; e.pc = m_pc + 16'd1; e.sp = m_hl; e.ime = m_ime; end
         8'hE9: begin e.cnt = 3'd1; e.pc = m_hl; e.sp = m_sp; e.ime = m_ime; end
         default: begin
            lo = m_sp[7:0] ^ 8'hA5;
            hi = 8'(m_sp + 16'd1) ^ 8'hA5;
            e.cnt = 3'd4; e.pc = {hi, lo}; e.sp = m_sp + 16'd2;
            e.ime = (op == 8'hD9) ? 1'b1 : m_ime;
         end
      endcase
      sb.push_back(e);
      rd0 = rd_cnt;
      issue(op);
      repeat (5) @(negedge clk);
      chk({tag, " drained"}, 32'(sb.size()), 32'd0);
      chk({tag, " reads R3 R6"}, 32'(rd_cnt - rd0), (op == 8'hE9 || op == 8'hF9) ? 32'd0 : 32'd2);
      m_pc = e.pc; m_sp = e.sp; m_ime = e.ime;
   endtask

   bit finished = 0;

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 pc", 32'(pc_o), 0);
      chk("R10 sp", 32'(sp_o), 0);
      chk("R10 hl", 32'(hl_o), 0);
      chk("R10 flags", 32'(flags_o), 0);
      chk("R10 ime", 32'(ime_o), 0);
      chk("R10 done/illegal/rd", {29'd0, done, illegal, mem_rd_en}, 0);
      rst_n = 1'b1;

      // R11 preload
      wr(3'd3, 16'h00B0);
      wr(3'd2, 16'h1234);
      wr(3'd0, 16'h0100);
      wr(3'd1, 16'hC000);
      chk("R11 preload hl", 32'(hl_o), 32'h1234);
      chk("R11 preload flags", 32'(flags_o), 32'hB0);

      // R1 R7 basic copy
      run(8'hF9, "R1 R7 ldsp 1234");
      wr(3'd2, 16'hFFFF);
      run(8'hF9, "R1 ldsp FFFF");
      wr(3'd2, 16'h0000);
      run(8'hF9, "R1 ldsp 0000");
      wr(3'd0, 16'hFFFF);
      run(8'hF9, "R7 pc wrap");

      // R3 jump tables
      wr(3'd2, 16'h4A5C);
      run(8'hE9, "R3 jp 4A5C");
      wr(3'd2, 16'h0008);
      run(8'hE9, "R3 jp 0008");

      // R5 plain return keeps ime 0, R4 restores it
      wr(3'd1, 16'hD000);
      run(8'hC9, "R5 ret ime0");
      chk("R5 ime stays 0", 32'(ime_o), 0);
      run(8'hD9, "R4 reti");
      chk("R4 ime set", 32'(ime_o), 1);
      run(8'hC9, "R5 ret ime1");

      // R6 pop across the top of memory
      wr(3'd1, 16'hFFFF);
      wr(3'd4, 16'h0000);
      run(8'hD9, "R6 R4 wrap pop");
      chk("R6 sp after wrap", 32'(sp_o), 32'h0001);

      // R2 different flag pattern
      wr(3'd3, 16'h0050);
      run(8'hC9, "R2 R5 flags 50");

      // R8 illegal opcode
      issue(8'h00);
      chk("R8 illegal pulse", 32'(illegal), 1);
      @(negedge clk);
      chk("R8 illegal one cycle", 32'(illegal), 0);
      chk("R8 pc kept", 32'(pc_o), 32'(m_pc));
      chk("R8 sp kept", 32'(sp_o), 32'(m_sp));
      chk("R8 flags kept", 32'(flags_o), 32'(m_fl));
      chk("R8 ime kept", 32'(ime_o), 32'(m_ime));
      chk("R8 no done", 32'(done), 0);

      // R9 start while busy is ignored
      wr(3'd2, 16'h7777);
      wr(3'd1, 16'hE010);
      begin
         exp_t e;
         e.cnt = 3'd4; e.pc = {8'h11 ^ 8'hA5, 8'h10 ^ 8'hA5}; e.sp = 16'hE012;
         e.hl = m_hl; e.fl = m_fl; e.ime = m_ime; e.tag = "R9 busy ret";
         sb.push_back(e);
         issue(8'hC9);
         issue(8'hE9);
         repeat (6) @(negedge clk);
         chk("R9 drained", 32'(sb.size()), 0);
         chk("R9 pc not hl", 32'(pc_o), 32'(e.pc));
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule